// File: doc/BRIEF.md
# Selectable Timing Pulse Generator

This block drives the timing pulse pin of a real-time clock. It takes the fifteen taps of a binary divider that is clocked from a 32.768 kHz reference, a one-second tick and an already-decoded three-bit mode code. From these it produces one open-drain output. Four of the mode codes select a 50 % duty square wave from a divider tap: 64 Hz, 256 Hz, 2048 Hz or 4096 Hz. The other four select a short pulse that repeats every 1, 10, 30 or 60 seconds.

In the interval modes the block keeps its own modulo-N count of second ticks. At each wrap of that count the block raises the output and holds it for one period of the 64 Hz tap. Any change of mode code clears the count, so the first interval after a switch is always a full interval.

The pin is modelled as a pull-down enable. When the internal pulse level is low, the output transistor is on. When the level is high, the pin is released and an external resistor pulls it up.

Top module: `tp_pulse_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset releases, the internal level is low, so `tp_sink` is 1. The interval count restarts from zero.
- R2: Mode codes 0, 1, 2 and 3 select 64 Hz, 256 Hz, 2048 Hz and 4096 Hz. These come from `div_taps` bits 8, 6, 3 and 2 (tap n sits at bit n-1, and tap 1 is 16384 Hz). The pin reflects the tap value sampled at the previous clock edge.
- R3: `tp_sink` is always the inverse of the pulse level. A high level releases the pin (`tp_sink` = 0) and a low level pulls it down (`tp_sink` = 1).
- R4: Mode codes 4, 5, 6 and 7 select intervals of 1, 10, 30 and 60 ticks. The level goes high in the cycle after the edge that samples the N-th `sec_tick` counted since the last wrap or mode change.
- R5: An interval pulse ends at the first rising edge of `div_taps[8]` sampled after the edge that started it. The level is low in the cycle after that rise is sampled.
- R6: A change of `mode_sel` between two clock edges clears the tick count and any pulse in progress. A tick sampled on that same edge is not counted.
- R7: In an interval mode, a wrap that coincides with an active pulse keeps the level high. A rise of the 64 Hz tap on that same edge does not end the pulse.
- R8: In the square-wave modes, `sec_tick` has no effect on the output. The tick count stays at zero, so a later switch into an interval mode starts a full interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples all inputs |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_taps | input | 15 | Divider taps, bit n-1 holds tap n (32768/2^n Hz) |
| sec_tick | input | 1 | One-cycle pulse once per second |
| mode_sel | input | 3 | Decoded mode: 0-3 square waves, 4-7 intervals |
| tp_sink | output | 1 | Open-drain pull-down enable, 1 pulls the pin low |

## Verification
The hardest situations to reach are the rare coincidences. One is a tick that wraps the count on the same edge that the 64 Hz tap rises while a pulse is still active. Another is a mode change that lands on a tick. The bench drives the divider taps from a free-running counter and issues ticks at short, prime-ish periods. This includes a tick on every cycle in the one-second mode, so wraps fall on every phase of the 64 Hz tap. Mode switches are placed mid-count and on tick cycles, and a behavioural model is compared with the pin on every clock.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic [2:0] {
    TP_SQ64  = 3'd0,
    TP_SQ256 = 3'd1,
    TP_SQ2K  = 3'd2,
    TP_SQ4K  = 3'd3,
    TP_IV1   = 3'd4,
    TP_IV10  = 3'd5,
    TP_IV30  = 3'd6,
    TP_IV60  = 3'd7
  } tp_mode_e;

  // codes with the top bit set count seconds
  function automatic logic is_interval(tp_mode_e m);
    return m[2];
  endfunction

  // interval length in ticks; 0 for square-wave modes
  function automatic int unsigned interval_len(tp_mode_e m);
    case (m)
      TP_IV1:  return 1;
      TP_IV10: return 10;
      TP_IV30: return 30;
      TP_IV60: return 60;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tp_tap_mux.sv
module tp_tap_mux #(
  parameter int DIV_STAGES = 15,
  parameter int TAP_SQ64   = 9,
  parameter int TAP_SQ256  = 7,
  parameter int TAP_SQ2K   = 4,
  parameter int TAP_SQ4K   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_STAGES-1:0] taps,
  input  tp_pkg::tp_mode_e      mode,
  output logic                  tap_q
);
  import tp_pkg::*;

  logic sel_bit;

  always_comb begin
    case (mode)
      TP_SQ256: sel_bit = taps[TAP_SQ256-1];
      TP_SQ2K:  sel_bit = taps[TAP_SQ2K-1];
      TP_SQ4K:  sel_bit = taps[TAP_SQ4K-1];
      default:  sel_bit = taps[TAP_SQ64-1];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= 1'b0;
    else        tap_q <= sel_bit;
  end

endmodule

// File: rtl/tp_interval_gen.sv
module tp_interval_gen #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tap64,
  input  logic             sec_tick,
  input  tp_pkg::tp_mode_e mode,
  input  logic             mode_chg,
  output logic             pulse_q
);
  import tp_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             tap64_d;
  logic             intv;
  logic [CNT_W-1:0] last_val;
  logic             wrap;
  logic             tap64_rise;

  assign intv       = is_interval(mode);
  assign last_val   = CNT_W'(interval_len(mode) - 1);
  assign wrap       = intv && !mode_chg && sec_tick && (cnt_q == last_val);
  assign tap64_rise = tap64 && !tap64_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tap64_d <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      tap64_d <= tap64;
      if (mode_chg || !intv) begin
        cnt_q   <= '0;
        pulse_q <= 1'b0;
      end else begin
        if (sec_tick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        if (wrap)                       pulse_q <= 1'b1;
        else if (pulse_q && tap64_rise) pulse_q <= 1'b0;
      end
    end
  end

  // R4
  rise_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(sec_tick));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (intv && !mode_chg) |-> (cnt_q <= last_val));

  // R6
  chg_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (cnt_q == '0) && !pulse_q);

  // R5
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && tap64_rise && !wrap) |=> !pulse_q);

endmodule

// File: rtl/tp_pulse_gen.sv
module tp_pulse_gen #(
  parameter int DIV_STAGES = 15,
  parameter int TAP_SQ64   = 9,
  parameter int TAP_SQ256  = 7,
  parameter int TAP_SQ2K   = 4,
  parameter int TAP_SQ4K   = 3,
  parameter int MAX_SECS   = 60,
  localparam int CNT_W     = $clog2(MAX_SECS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_STAGES-1:0] div_taps,
  input  logic                  sec_tick,
  input  logic [2:0]            mode_sel,
  output logic                  tp_sink
);
  import tp_pkg::*;

  tp_mode_e mode, mode_q;
  logic     mode_chg;
  logic     tap_q;
  logic     pulse_q;
  logic     level;

  assign mode     = tp_mode_e'(mode_sel);
  assign mode_chg = (mode != mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= TP_SQ64;
    else        mode_q <= mode;
  end

  tp_tap_mux #(
    .DIV_STAGES(DIV_STAGES), .TAP_SQ64(TAP_SQ64), .TAP_SQ256(TAP_SQ256),
    .TAP_SQ2K(TAP_SQ2K), .TAP_SQ4K(TAP_SQ4K)
  ) u_mux (
    .clk(clk), .rst_n(rst_n), .taps(div_taps), .mode(mode), .tap_q(tap_q)
  );

  tp_interval_gen #(.CNT_W(CNT_W)) u_intv (
    .clk(clk), .rst_n(rst_n), .tap64(div_taps[TAP_SQ64-1]),
    .sec_tick(sec_tick), .mode(mode), .mode_chg(mode_chg), .pulse_q(pulse_q)
  );

  assign level   = is_interval(mode_q) ? pulse_q : tap_q;
  assign tp_sink = !level;

  // R8
  sq_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_interval(mode_q) |-> !pulse_q);

endmodule

// File: tb/tp_pulse_gen_test.sv
module tp_pulse_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] div = '0;
  logic        tick = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        sink;

  int tests = 0, fails = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  tp_pulse_gen uut (.clk(clk), .rst_n(rst_n), .div_taps(div), .sec_tick(tick),
                    .mode_sel(mode), .tp_sink(sink));

  // behavioural reference
  int m_cnt = 0, m_pulse = 0, m_tap = 0, m_prev_mode = 0, m_prev64 = 0, m_level = 0;
  int lens[8]  = '{0, 0, 0, 0, 1, 10, 30, 60};
  int tapb[8]  = '{8, 6, 3, 2, 8, 8, 8, 8};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pulse = 0; m_tap = 0; m_prev_mode = 0; m_prev64 = 0; m_level = 0;
    end else begin
      int md, rise, wrap;
      md   = int'(mode);
      rise = (div[8] && !m_prev64) ? 1 : 0;
      wrap = 0;
      m_tap = int'(div[tapb[md]]);
      if (md != m_prev_mode || md < 4) begin
        m_cnt = 0; m_pulse = 0;
      end else begin
        if (tick) begin
          if (m_cnt == lens[md] - 1) begin m_cnt = 0; wrap = 1; end
          else m_cnt++;
        end
        if (wrap) m_pulse = 1;
        else if (m_pulse != 0 && rise != 0) m_pulse = 0;
      end
      m_prev64 = int'(div[8]);
      m_prev_mode = md;
      m_level = (md >= 4) ? m_pulse : m_tap;
    end
  end

  task automatic check(string t, logic exp_sink);
    tests++;
    if (sink !== exp_sink) begin
      fails++;
      $display("FAIL %s: tp_sink=%b expected %b at %0t", t, sink, exp_sink, $time);
    end
  endtask

  // one cycle: compare at negedge, then drive new inputs
  task automatic step(int period, int n);
    @(negedge clk);
    check(tag, (m_level == 0));
    check("R3", !(m_level != 0) == sink ? sink : !sink); // R3: sink is inverse of level
    div  = div + 1'b1;
    tick = (period > 0) && (n % period == 0);
  endtask

  task automatic run(int md, int cycles, int period);
    mode = 3'(md);
    for (int i = 1; i <= cycles; i++) step(period, i);
  endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b1);
    // R2, R8: square-wave modes with ticks present
    tag = "R2";
    for (int m = 0; m < 4; m++) run(m, 1100, 50);
    tag = "R8";
    run(1, 300, 1);
    // R4, R5: every interval mode
    tag = "R4,R5";
    run(4, 800, 40);
    run(5, 40 * 25, 40);
    run(6, 40 * 70, 37);
    run(7, 40 * 130, 41);
    // R6: mode changes mid-count and on tick cycles
    tag = "R6";
    run(7, 40 * 45, 40);
    run(5, 41, 41);
    run(6, 40 * 12, 40);
    run(7, 1, 1);
    run(5, 30 * 15, 30);
    run(2, 5, 1);
    run(5, 30 * 12, 30);
    // R7: wraps on every cycle and coinciding with tap rises
    tag = "R7";
    run(4, 2100, 1);
    run(4, 1600, 3);
    run(5, 2048, 2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule